// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Controller

This block collects sixteen interrupt sources, chooses one of them and presents a single registered request with its vector address to a CPU core. Each source has a pending flag, an individual enable and a priority bit. Source 0 is power-fail. It owns a third, topmost level and ignores the global enable. Every other source sits at level high or low, selected by its priority bit. Within a level, a fixed natural order breaks ties.

When the core acknowledges a request, the block records the level of the request in an in-service stack. It also clears the flag of the taken source, but only where that source clears on entry. A return strobe pops the highest level in service. A new request is raised only if its level is strictly above every level still in service. The peripherals that set the flags and the core itself are outside the block.

Top module: `irq3_ctrl`

## Requirements
- R1: After reset `irq_o` is 0, and all enables, priority bits, the global enable and the in-service stack are 0, so pending flags raise no request.
- R2: Sources 1 to 15 can raise a request only when their enable bit and the global enable are both 1. Source 0 needs only its own enable bit, `en_wdata_i[0]`.
- R3: Source 0 is at level 2, the top level. Source i (1..15) is at level 1 when `prio_wdata_i[i]` was written as 1, and at level 0 otherwise. `prio_wdata_i[0]` has no effect. The highest eligible level wins.
- R4: Within one level, the lowest source index wins. The indices are: 0 power-fail, 1 ext0, 2 timer0, 3 ext1, 4 timer1, 5 serial0, 6 timer2, 7 serial1, 8..11 ext2..ext5, 12 bus controller 0, 13 bus controller 1, 14 watchdog, 15 bus activity.
- R5: `vector_o` for sources 0..15 is 33h, 03h, 0Bh, 13h, 1Bh, 23h, 2Bh, 3Bh, 43h, 4Bh, 53h, 5Bh, 6Bh, 73h, 63h, 7Bh. It is valid whenever `irq_o` is 1.
- R6: `irq_o` is registered. A flag set at a clock edge raises `irq_o` at the following edge, and the vector is already valid in that cycle.
- R7: `ack_i` while `irq_o` is 1 pushes the winner's level and drops `irq_o` at the next edge. `ack_i` while `irq_o` is 0 has no effect.
- R8: An acknowledge clears the flag of timer0 (2), of timer1 (4), and of ext0 or ext1 when that line is in edge mode.
- R9: In level mode (`ext_edge_i` bit 0 for ext0, bit 1 for ext1, value 0), the pending state of ext0/ext1 follows the pin, which is `src_set_i[1]` or `src_set_i[3]`, and an acknowledge does not clear it. Serial port k is pending while `ser_rx_i[k]` or `ser_tx_i[k]` is 1.
- R10: All other stored flags stay set after an acknowledge, until a 1 on their `src_clr_i` bit. A 1 on `src_set_i` sets the flag; a set in the same cycle overrides a clear.
- R11: A request is raised only if its level is strictly above the highest level in service. `reti_i` clears the highest set in-service bit.
- R12: In edge mode (`ext_edge_i` bit 1), a rising edge of the ext0 or ext1 pin sets its flag once; a pin held high does not set it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_set_i | input | 16 | Flag set pulses; pins for ext0 (bit 1) and ext1 (bit 3) |
| src_clr_i | input | 16 | Flag clear pulses, driven by software |
| ext_edge_i | input | 2 | Edge (1) or level (0) mode for ext0 and ext1 |
| ser_rx_i | input | 2 | Receive flags of serial ports 0 and 1 |
| ser_tx_i | input | 2 | Transmit flags of serial ports 0 and 1 |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 16 | Enable register write data |
| prio_we_i | input | 1 | Priority register write strobe |
| prio_wdata_i | input | 16 | Priority register write data |
| glb_we_i | input | 1 | Global enable write strobe |
| glb_wdata_i | input | 1 | Global enable write data |
| ack_i | input | 1 | Acknowledge from the core |
| reti_i | input | 1 | Return from interrupt strobe |
| irq_o | output | 1 | Registered interrupt request |
| vector_o | output | 8 | Vector address of the winning source |

## Verification
A wrong bit in the in-service stack shows at the ports as a request that is missing or comes early. A stale high bit holds back requests of equal or lower level. A lost bit lets an equal-level source interrupt its own level. Either shows within two cycles of the next acknowledge or return. A flag that is wrongly kept or wrongly dropped after an acknowledge shows two cycles after the return strobe, as a repeated or missing vector. The bench runs a cycle model and compares every cycle, so a divergence is caught on the cycle it reaches `irq_o` or `vector_o`.

// File: rtl/irq3_pkg.sv
package irq3_pkg;
  localparam int NSRC = 16;
  localparam int NLVL = 3;
  localparam int LVLW = 2;

  typedef enum logic [1:0] {K_PLAIN, K_AUTO, K_EXT, K_SER} src_kind_e;

  function automatic src_kind_e kind_of(input int i);
    case (i)
      1, 3:    return K_EXT;
      2, 4:    return K_AUTO;
      5, 7:    return K_SER;
      default: return K_PLAIN;
    endcase
  endfunction

  function automatic int ext_slot(input int i);
    return (i == 3) ? 1 : 0;
  endfunction

  function automatic int ser_slot(input int i);
    return (i == 7) ? 1 : 0;
  endfunction

  function automatic logic [7:0] vec_of(input int i);
    case (i)
      0:       return 8'h33;
      12:      return 8'h6B;
      13:      return 8'h73;
      14:      return 8'h63;
      15:      return 8'h7B;
      default: return 8'((((i >= 1) && (i <= 6)) ? (i - 1) : i) * 8 + 3);
    endcase
  endfunction
endpackage

// File: rtl/irq3_flags.sv
module irq3_flags
  import irq3_pkg::*;
#(
  parameter int N    = NSRC,
  parameter int IDXW = $clog2(N)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    set_i,
  input  logic [N-1:0]    clr_i,
  input  logic [1:0]      edge_mode_i,
  input  logic [1:0]      ser_rx_i,
  input  logic [1:0]      ser_tx_i,
  input  logic            take_i,
  input  logic [IDXW-1:0] take_idx_i,
  output logic [N-1:0]    pend_o
);

  for (genvar g = 0; g < N; g++) begin : g_src
    localparam src_kind_e KIND = kind_of(g);

    if (KIND == K_SER) begin : g_ser
      localparam int S = ser_slot(g);
      logic unused_ser;
      assign unused_ser = set_i[g] ^ clr_i[g];
      assign pend_o[g]  = ser_rx_i[S] | ser_tx_i[S];
    end else if (KIND == K_EXT) begin : g_ext
      localparam int S = ext_slot(g);
      logic flag_q, pin_q, hit, lvl_md;
      assign hit    = take_i && (take_idx_i == IDXW'(g));
      assign lvl_md = !edge_mode_i[S];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          pin_q  <= 1'b0;
          flag_q <= 1'b0;
        end else begin
          pin_q  <= set_i[g];
          flag_q <= lvl_md ? 1'b0
                           : ((flag_q & ~clr_i[g] & ~hit) | (set_i[g] & ~pin_q));
        end
      end
      assign pend_o[g] = lvl_md ? set_i[g] : flag_q;
    end else begin : g_st
      logic flag_q, hit;
      assign hit = take_i && (take_idx_i == IDXW'(g)) && (KIND == K_AUTO);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flag_q <= 1'b0;
        else         flag_q <= (flag_q & ~clr_i[g] & ~hit) | set_i[g];
      end
      assign pend_o[g] = flag_q;
    end
  end

endmodule

// File: rtl/irq3_arb.sv
module irq3_arb
  import irq3_pkg::*;
#(
  parameter int N    = NSRC,
  parameter int IDXW = $clog2(N)
) (
  input  logic [N-1:0]    pend_i,
  input  logic [N-1:0]    en_i,
  input  logic [N-1:0]    prio_i,
  input  logic            glb_i,
  input  logic [NLVL-1:0] isr_i,
  output logic            req_o,
  output logic [IDXW-1:0] idx_o,
  output logic [LVLW-1:0] lvl_o
);

  logic [N-1:0]                 elig;
  logic [N-1:0][LVLW-1:0]       slvl;
  logic [NLVL-1:0][N-1:0]       lmask;
  logic [NLVL-1:0]              any_l, allow_l;
  logic [NLVL-1:0][IDXW-1:0]    low_l;
  logic                         unused_prio0;

  assign unused_prio0 = prio_i[0];

  for (genvar g = 0; g < N; g++) begin : g_src
    if (g == 0) begin : g_top
      assign elig[g] = pend_i[g] & en_i[g];
      assign slvl[g] = LVLW'(NLVL - 1);
    end else begin : g_usr
      assign elig[g] = pend_i[g] & en_i[g] & glb_i;
      assign slvl[g] = prio_i[g] ? LVLW'(1) : LVLW'(0);
    end
  end

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    for (genvar g = 0; g < N; g++) begin : g_m
      assign lmask[l][g] = elig[g] && (slvl[g] == LVLW'(l));
    end
    assign any_l[l]   = |lmask[l];
    // strictly above every in-service level
    assign allow_l[l] = (isr_i >> l) == '0;
    always_comb begin
      low_l[l] = '0;
      for (int i = N - 1; i >= 0; i--) begin
        if (lmask[l][i]) low_l[l] = IDXW'(i);
      end
    end
  end

  always_comb begin
    req_o = 1'b0;
    idx_o = '0;
    lvl_o = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (any_l[l] && allow_l[l]) begin
        req_o = 1'b1;
        idx_o = low_l[l];
        lvl_o = LVLW'(l);
      end
    end
  end

endmodule

// File: rtl/irq3_nest.sv
module irq3_nest
  import irq3_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  logic [LVLW-1:0] take_lvl_i,
  input  logic            reti_i,
  output logic [NLVL-1:0] isr_o
);

  logic [NLVL-1:0] isr_q, isr_d, top_1h;

  always_comb begin
    top_1h = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (isr_q[l]) top_1h = NLVL'(1) << l;
    end
    isr_d = isr_q;
    if (reti_i) isr_d = isr_d & ~top_1h;
    if (take_i) isr_d = isr_d | (NLVL'(1) << take_lvl_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= isr_d;
  end

  assign isr_o = isr_q;

endmodule

// File: rtl/irq3_ctrl.sv
module irq3_ctrl
  import irq3_pkg::*;
#(
  parameter int NUM_SRC = NSRC,
  parameter int VEC_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_set_i,
  input  logic [NUM_SRC-1:0] src_clr_i,
  input  logic [1:0]         ext_edge_i,
  input  logic [1:0]         ser_rx_i,
  input  logic [1:0]         ser_tx_i,
  input  logic               en_we_i,
  input  logic [NUM_SRC-1:0] en_wdata_i,
  input  logic               prio_we_i,
  input  logic [NUM_SRC-1:0] prio_wdata_i,
  input  logic               glb_we_i,
  input  logic               glb_wdata_i,
  input  logic               ack_i,
  input  logic               reti_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vector_o
);

  localparam int IDXW = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] en_q, prio_q, pend;
  logic               glb_q;
  logic               req_c, take, irq_q;
  logic [IDXW-1:0]    idx_c, idx_q;
  logic [LVLW-1:0]    lvl_c, lvl_q;
  logic [NLVL-1:0]    isr_w;
  logic [VEC_W-1:0]   vec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      prio_q <= '0;
      glb_q  <= 1'b0;
    end else begin
      if (en_we_i)   en_q   <= en_wdata_i;
      if (prio_we_i) prio_q <= prio_wdata_i;
      if (glb_we_i)  glb_q  <= glb_wdata_i;
    end
  end

  assign take = ack_i & irq_q;

  irq3_flags #(.N(NUM_SRC), .IDXW(IDXW)) u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (src_set_i),
    .clr_i       (src_clr_i),
    .edge_mode_i (ext_edge_i),
    .ser_rx_i    (ser_rx_i),
    .ser_tx_i    (ser_tx_i),
    .take_i      (take),
    .take_idx_i  (idx_q),
    .pend_o      (pend)
  );

  irq3_arb #(.N(NUM_SRC), .IDXW(IDXW)) u_arb (
    .pend_i (pend),
    .en_i   (en_q),
    .prio_i (prio_q),
    .glb_i  (glb_q),
    .isr_i  (isr_w),
    .req_o  (req_c),
    .idx_o  (idx_c),
    .lvl_o  (lvl_c)
  );

  irq3_nest u_nest (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take),
    .take_lvl_i (lvl_q),
    .reti_i     (reti_i),
    .isr_o      (isr_w)
  );

  // request computed before an acknowledge is stale, so drop it for one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      idx_q <= '0;
      lvl_q <= '0;
      vec_q <= '0;
    end else begin
      irq_q <= take ? 1'b0 : req_c;
      if (req_c) begin
        idx_q <= idx_c;
        lvl_q <= lvl_c;
        vec_q <= VEC_W'(vec_of(int'(idx_c)));
      end
    end
  end

  assign irq_o    = irq_q;
  assign vector_o = vec_q;

endmodule

// File: rtl/irq3_ctrl_chk.sv
module irq3_ctrl_chk
  import irq3_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ack_i,
  input logic            reti_i,
  input logic            irq_o,
  input logic [7:0]      vector_o,
  input logic [NLVL-1:0] isr_i,
  input logic [LVLW-1:0] lvl_i,
  input logic            glb_i
);

  p_ack_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && irq_o |=> !irq_o);

  p_vec_form_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (vector_o[2:0] == 3'b011));

  p_push_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && irq_o |=> (((isr_i >> $past(lvl_i)) & NLVL'(1)) == NLVL'(1)));

  p_pop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reti_i && !(ack_i && irq_o) && (isr_i != '0)
      |=> ($countones(isr_i) == $countones($past(isr_i)) - 1));

  p_preempt_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((isr_i >> lvl_i) == '0));

  p_glb_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !$past(glb_i) |-> (vector_o == 8'h33));

endmodule

bind irq3_ctrl irq3_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ack_i    (ack_i),
  .reti_i   (reti_i),
  .irq_o    (irq_o),
  .vector_o (vector_o),
  .isr_i    (isr_w),
  .lvl_i    (lvl_q),
  .glb_i    (glb_q)
);

// File: tb/tb_irq3_ctrl.sv
module tb_irq3_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] src_set = '0, src_clr = '0, en_wdata = '0, prio_wdata = '0;
  logic [1:0]  ext_edge = '0, ser_rx = '0, ser_tx = '0;
  logic        en_we = 0, prio_we = 0, glb_we = 0, glb_wdata = 0, ack = 0, reti = 0;
  logic        irq;
  logic [7:0]  vec;

  int errors = 0, checks = 0;
  bit done = 0;
  string tag = "R1";

  // reference state
  logic [15:0] m_flag, m_en, m_prio;
  logic [1:0]  m_pinq;
  logic        m_glb, m_irq;
  logic [2:0]  m_isr;
  logic [7:0]  m_vec;
  int          m_idx, m_lvl;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq3_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .src_set_i(src_set), .src_clr_i(src_clr),
    .ext_edge_i(ext_edge), .ser_rx_i(ser_rx), .ser_tx_i(ser_tx),
    .en_we_i(en_we), .en_wdata_i(en_wdata), .prio_we_i(prio_we),
    .prio_wdata_i(prio_wdata), .glb_we_i(glb_we), .glb_wdata_i(glb_wdata),
    .ack_i(ack), .reti_i(reti), .irq_o(irq), .vector_o(vec)
  );

  function automatic logic [7:0] exp_vec(input int i);
    logic [7:0] t [16] = '{8'h33, 8'h03, 8'h0B, 8'h13, 8'h1B, 8'h23, 8'h2B, 8'h3B,
                           8'h43, 8'h4B, 8'h53, 8'h5B, 8'h6B, 8'h73, 8'h63, 8'h7B};
    return t[i];
  endfunction

  function automatic logic m_pending(input int i);
    case (i)
      1: return ext_edge[0] ? m_flag[1] : src_set[1];
      3: return ext_edge[1] ? m_flag[3] : src_set[3];
      5: return ser_rx[0] | ser_tx[0];
      7: return ser_rx[1] | ser_tx[1];
      default: return m_flag[i];
    endcase
  endfunction

  task automatic model_update();
    int top, best, bi, l;
    logic take;
    logic [15:0] nf;
    logic [2:0] ni;
    top = m_isr[2] ? 2 : m_isr[1] ? 1 : m_isr[0] ? 0 : -1;
    best = -1; bi = 0;
    for (int i = 0; i < 16; i++) begin
      if (m_pending(i) && m_en[i] && (i == 0 || m_glb)) begin
        l = (i == 0) ? 2 : (m_prio[i] ? 1 : 0);
        if (l > top && l > best) begin best = l; bi = i; end
      end
    end
    take = ack && m_irq;
    nf = m_flag;
    for (int i = 0; i < 16; i++) begin
      if (i == 1 || i == 3) begin
        if (ext_edge[i / 2])
          nf[i] = (m_flag[i] & ~src_clr[i] & ~(take && m_idx == i))
                  | (src_set[i] & ~m_pinq[i / 2]);
        else nf[i] = 1'b0;
      end else if (i != 5 && i != 7) begin
        nf[i] = (m_flag[i] & ~src_clr[i] & ~(take && m_idx == i && (i == 2 || i == 4)))
                | src_set[i];
      end
    end
    ni = m_isr;
    if (reti) begin
      if (ni[2]) ni[2] = 0; else if (ni[1]) ni[1] = 0; else ni[0] = 0;
    end
    if (take) ni[m_lvl] = 1'b1;
    m_flag = nf;
    m_pinq = {src_set[3], src_set[1]};
    m_isr  = ni;
    m_irq  = take ? 1'b0 : (best >= 0);
    if (best >= 0) begin m_idx = bi; m_lvl = best; m_vec = exp_vec(bi); end
    if (en_we) m_en = en_wdata;
    if (prio_we) m_prio = prio_wdata;
    if (glb_we) m_glb = glb_wdata;
  endtask

  task automatic chk(input string t, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", t, what, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk(tag, "irq_o", 32'(irq), 32'(m_irq));
    if (m_irq) chk(tag, "vector_o", 32'(vec), 32'(m_vec));
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic p_set(input logic [15:0] m);  src_set = m; step(); src_set = '0; endtask
  task automatic p_clr(input logic [15:0] m);  src_clr = m; step(); src_clr = '0; endtask
  task automatic p_ack();  ack = 1;  step(); ack = 0;  endtask
  task automatic p_reti(); reti = 1; step(); reti = 0; endtask
  task automatic w_en(input logic [15:0] d);   en_we = 1; en_wdata = d; step(); en_we = 0; endtask
  task automatic w_prio(input logic [15:0] d); prio_we = 1; prio_wdata = d; step(); prio_we = 0; endtask
  task automatic w_glb(input logic d);         glb_we = 1; glb_wdata = d; step(); glb_we = 0; endtask

  task automatic expect_out(input string t, input logic ei, input logic [7:0] ev);
    chk(t, "irq_o", 32'(irq), 32'(ei));
    if (ei) chk(t, "vector_o", 32'(vec), 32'(ev));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_flag = '0; m_en = '0; m_prio = '0; m_pinq = '0; m_glb = 0; m_irq = 0;
    m_isr = '0; m_vec = '0; m_idx = 0; m_lvl = 0;
    repeat (3) @(negedge clk);
    chk("R1", "irq_o in reset", 32'(irq), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: flags without enables raise nothing
    tag = "R1";
    p_set(16'hFFFF);
    run(3);
    expect_out("R1", 0, 0);
    // R2: global enable clear leaves only power-fail
    tag = "R2";
    w_en(16'hFFFF); run(2);
    expect_out("R2", 1, 8'h33);
    p_clr(16'h0001); run(2);
    expect_out("R2", 0, 0);
    // R4: lowest index wins within level
    tag = "R4";
    w_glb(1); run(2);
    expect_out("R4", 1, 8'h0B);
    // R3: priority bit lifts source 15
    tag = "R3";
    w_prio(16'h8000); run(2);
    expect_out("R3", 1, 8'h7B);
    // R7 and R11: nesting and preemption
    tag = "R11";
    p_ack();
    expect_out("R7", 0, 0);
    run(2);
    expect_out("R11", 0, 0);
    p_set(16'h0001); run(2);
    expect_out("R11", 1, 8'h33);
    p_ack(); p_reti(); run(2);
    expect_out("R11", 1, 8'h33);
    p_clr(16'h0001); run(2);
    expect_out("R11", 0, 0);
    p_reti(); run(2);
    expect_out("R11", 1, 8'h7B);
    // R8: timer flags clear on acknowledge
    tag = "R8";
    w_prio(16'h0000);
    p_clr(16'hFFEB); run(2);
    expect_out("R8", 1, 8'h0B);
    p_ack(); p_reti(); run(2);
    expect_out("R8", 1, 8'h1B);
    p_ack(); p_reti(); run(2);
    expect_out("R8", 0, 0);
    // R12: edge mode sets once per rising edge
    tag = "R12";
    ext_edge = 2'b01; src_set[1] = 1'b1; run(3);
    expect_out("R12", 1, 8'h03);
    p_ack(); p_reti(); run(3);
    expect_out("R12", 0, 0);
    src_set[1] = 1'b0; step();
    // R9: level mode and serial lines follow their inputs
    tag = "R9";
    ext_edge = 2'b00; src_set[3] = 1'b1; run(2);
    expect_out("R9", 1, 8'h13);
    p_ack(); p_reti(); run(2);
    expect_out("R9", 1, 8'h13);
    src_set[3] = 1'b0; run(2);
    expect_out("R9", 0, 0);
    ser_tx[1] = 1'b1; run(2);
    expect_out("R9", 1, 8'h3B);
    p_ack(); p_reti(); run(2);
    expect_out("R9", 1, 8'h3B);
    ser_tx[1] = 1'b0; run(2);
    // R10: plain flags persist until cleared
    tag = "R10";
    p_set(16'h4000); run(2);
    expect_out("R10", 1, 8'h63);
    p_ack(); p_reti(); run(2);
    expect_out("R10", 1, 8'h63);
    p_clr(16'h4000); run(2);
    expect_out("R10", 0, 0);
    // R6: one registered cycle from flag to request
    tag = "R6";
    p_set(16'h1000);
    expect_out("R6", 0, 0);
    step();
    expect_out("R6", 1, 8'h6B);
    // R7: acknowledge without request is ignored
    tag = "R7";
    p_ack(); p_reti(); p_clr(16'h1000); run(2);
    expect_out("R7", 0, 0);
    p_ack();
    p_set(16'h2000); run(2);
    expect_out("R7", 1, 8'h73);
    p_ack(); p_reti(); p_clr(16'h2000); run(2);
    // R5: random traffic over all sources and vectors
    tag = "R5";
    for (int c = 0; c < 6000; c++) begin
      src_set = ($urandom % 6 == 0) ? (16'h1 << ($urandom % 16)) : 16'h0;
      src_clr = ($urandom % 5 == 0) ? 16'($urandom) : 16'h0;
      ser_rx  = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
      ser_tx  = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
      if ($urandom % 50 == 0) ext_edge = 2'($urandom);
      en_we = ($urandom % 40 == 0); en_wdata = 16'($urandom) | 16'h8001;
      prio_we = ($urandom % 40 == 0); prio_wdata = 16'($urandom);
      glb_we = ($urandom % 60 == 0); glb_wdata = ($urandom % 4 != 0);
      ack  = m_irq && ($urandom % 2 == 0);
      reti = ($urandom % 6 == 0);
      step();
    end
    src_set = '0; src_clr = '0; ser_rx = '0; ser_tx = '0;
    en_we = 0; prio_we = 0; glb_we = 0; ack = 0; reti = 0;
    run(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule